// File: doc/BRIEF.md
# Multiply and Byte-Reverse Execution Slice

This block is one execution slice of a small 32-bit processor. It holds an eight-entry register bank and a four-bit condition flag register. A request names an opcode, a destination index and two source indices. The slice runs one of four operations. The first is an iterative multiply that keeps the low word of the product. The other three are single-cycle byte reorderings: full-word reverse, reverse inside each halfword, and low-halfword reverse with sign extension. Each result is written back to the bank, and a write-back pulse announces it.

The multiply is sign-agnostic and runs one shift-and-add step per cycle, with busy held high while it runs. It updates only the negative and zero flags. A multiply whose destination differs from its second source index is refused with an error pulse. A load port lets surrounding logic fill registers and flags. A peek port reads any register without side effects.

Top module: `mulrev_unit`

## Requirements
- R1: Synchronous active-high reset clears all eight registers, all four flags, busy, done, err and wb_valid to zero.
- R2: Opcode 0 (multiply) writes the low 32 bits of rn×rm into rd. The result is the same whether the operands are read as signed or unsigned.
- R3: After a multiply, flags[3] (N) equals bit 31 of the result and flags[2] (Z) is 1 exactly when the result is zero. flags[1] (C) and flags[0] (V) keep their previous values.
- R4: A multiply request with rd not equal to rm gives a one-cycle err pulse in the next cycle. It starts nothing, writes no register and changes no flag.
- R5: An accepted multiply holds busy high for exactly 32 cycles, starting in the cycle after the request. done and wb_valid pulse for one cycle right after busy falls, and at that point the register and flags already hold the new values.
- R6: Opcode 1 writes rn with its byte order reversed to rd: input bytes 3,2,1,0 become output bytes 0,1,2,3.
- R7: Opcode 2 swaps the two bytes inside each 16-bit half of rn independently and writes the result to rd.
- R8: Opcode 3 swaps the two bytes of the low half of rn, then sign-extends the swapped 16-bit value (whose bit 15 is input bit 7) to 32 bits, and writes it to rd.
- R9: A reverse operation changes no flag. Its result is in rd, and wb_valid pulses, in the cycle after the request.
- R10: A request of any opcode presented while busy is high is ignored. It causes no write-back and no err pulse.
- R11: Register specifiers are 3 bits wide and address registers 0 to 7. ld_we writes ld_data into register ld_idx, and flag_we loads flags from flag_in, one cycle later. peek_data always shows register peek_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operation request strobe |
| req_op | input | 2 | 0 multiply, 1 word reverse, 2 halfword reverse, 3 reverse with sign extend |
| req_rd | input | 3 | Destination register index |
| req_rn | input | 3 | First source register index |
| req_rm | input | 3 | Second source register index (multiply only) |
| ld_we | input | 1 | External register load enable |
| ld_idx | input | 3 | External load register index |
| ld_data | input | 32 | External load data |
| flag_we | input | 1 | External flag load enable |
| flag_in | input | 4 | Flag load value {N,Z,C,V} |
| peek_idx | input | 3 | Register index for the read-only view |
| peek_data | output | 32 | Contents of register peek_idx |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | Multiply completion pulse |
| err | output | 1 | Rejected request pulse |
| wb_valid | output | 1 | Write-back pulse |
| wb_idx | output | 3 | Register written by the last write-back |
| wb_data | output | 32 | Value written by the last write-back |
| flags | output | 4 | Condition flags {N,Z,C,V} |

## Verification
The checker watches every cycle for these properties. The busy window must last exactly 32 cycles, and done must follow the fall of busy as a single pulse. After a multiply, N and Z must match the written word, while C and V stay put unless the flag port loads them. Reverse write-backs must leave every flag unchanged. An error must never coincide with a write-back or a running multiply, and no error may follow a cycle spent busy. The bench scenarios cover what only concrete values show: the product's low word for mixed-sign and overflowing operands, each byte arrangement, a sign-extended result, and rejected or ignored requests that leave the peeked registers unchanged.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

    typedef enum logic [1:0] {
        OP_MUL   = 2'd0,
        OP_REV   = 2'd1,
        OP_REV16 = 2'd2,
        OP_REVSH = 2'd3
    } op_e;

    // bit positions inside the four-bit flag word
    localparam int FLG_N = 3;
    localparam int FLG_Z = 2;
    localparam int FLG_C = 1;
    localparam int FLG_V = 0;

endpackage

// File: rtl/mrx_regbank.sv
module mrx_regbank #(
    parameter int XLEN  = 32,
    parameter int NREGS = 8,
    localparam int IDXW = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [IDXW-1:0] widx,
    input  logic [XLEN-1:0] wdata,
    input  logic [IDXW-1:0] ra_idx,
    output logic [XLEN-1:0] ra_data,
    input  logic [IDXW-1:0] rb_idx,
    output logic [XLEN-1:0] rb_data,
    input  logic [IDXW-1:0] rc_idx,
    output logic [XLEN-1:0] rc_data
);

    logic [XLEN-1:0] regs_q [NREGS];
    logic [XLEN-1:0] regs_d [NREGS];

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            regs_d[widx] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '{default: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ra_data = regs_q[ra_idx];
    assign rb_data = regs_q[rb_idx];
    assign rc_data = regs_q[rc_idx];

endmodule

// File: rtl/mrx_byteswap.sv
module mrx_byteswap #(
    parameter int XLEN = 32
) (
    input  mrx_pkg::op_e    op,
    input  logic [XLEN-1:0] src,
    output logic [XLEN-1:0] res
);
    import mrx_pkg::*;

    localparam int NBYTES = XLEN / 8;
    localparam int NHALF  = XLEN / 16;

    logic [XLEN-1:0] word_rev;
    logic [XLEN-1:0] half_rev;
    logic [XLEN-1:0] sext_rev;

    for (genvar b = 0; b < NBYTES; b++) begin : g_word
        assign word_rev[b*8 +: 8] = src[(NBYTES-1-b)*8 +: 8];
    end

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        assign half_rev[h*16     +: 8] = src[h*16 + 8 +: 8];
        assign half_rev[h*16 + 8 +: 8] = src[h*16     +: 8];
    end

    assign sext_rev = {{(XLEN-16){src[7]}}, src[7:0], src[15:8]};

    always_comb begin
        case (op)
            OP_REV16: res = half_rev;
            OP_REVSH: res = sext_rev;
            default:  res = word_rev;
        endcase
    end

endmodule

// File: rtl/mrx_seqmul.sv
module mrx_seqmul #(
    parameter int XLEN = 32,
    localparam int CW  = $clog2(XLEN)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    output logic            busy,
    output logic            last,
    output logic [XLEN-1:0] result
);

    typedef struct packed {
        logic            busy;
        logic [CW-1:0]   cnt;
        logic [XLEN-1:0] acc;
        logic [XLEN-1:0] ma;
        logic [XLEN-1:0] mb;
    } mstate_t;

    mstate_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            st_d.acc = st_q.acc + (st_q.mb[0] ? st_q.ma : '0);
            st_d.ma  = st_q.ma << 1;
            st_d.mb  = st_q.mb >> 1;
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CW'(XLEN-1)) begin
                st_d.busy = 1'b0;
            end
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
            st_d.acc  = '0;
            st_d.ma   = op_a;
            st_d.mb   = op_b;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy   = st_q.busy;
    assign last   = st_q.busy && (st_q.cnt == CW'(XLEN-1));
    assign result = st_d.acc;

endmodule

// File: rtl/mulrev_unit.sv
module mulrev_unit #(
    parameter int XLEN  = 32,
    parameter int NREGS = 8,
    localparam int IDXW = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [1:0]      req_op,
    input  logic [IDXW-1:0] req_rd,
    input  logic [IDXW-1:0] req_rn,
    input  logic [IDXW-1:0] req_rm,
    input  logic            ld_we,
    input  logic [IDXW-1:0] ld_idx,
    input  logic [XLEN-1:0] ld_data,
    input  logic            flag_we,
    input  logic [3:0]      flag_in,
    input  logic [IDXW-1:0] peek_idx,
    output logic [XLEN-1:0] peek_data,
    output logic            busy,
    output logic            done,
    output logic            err,
    output logic            wb_valid,
    output logic [IDXW-1:0] wb_idx,
    output logic [XLEN-1:0] wb_data,
    output logic [3:0]      flags
);
    import mrx_pkg::*;

    typedef struct packed {
        logic            done;
        logic            err;
        logic            wbv;
        logic [IDXW-1:0] wbidx;
        logic [XLEN-1:0] wbdata;
        logic [IDXW-1:0] mrd;
        logic [3:0]      flg;
    } ctl_t;

    ctl_t st_q, st_d;

    op_e             op_w;
    logic [XLEN-1:0] src_a, src_b, swap_res, mul_res;
    logic            mul_busy, mul_last, mul_start;
    logic            accept, is_mul, rev_go;
    logic            bank_we;
    logic [IDXW-1:0] bank_widx;
    logic [XLEN-1:0] bank_wdata;

    assign op_w = op_e'(req_op);

    mrx_regbank #(.XLEN(XLEN), .NREGS(NREGS)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .we      (bank_we),
        .widx    (bank_widx),
        .wdata   (bank_wdata),
        .ra_idx  (req_rn),
        .ra_data (src_a),
        .rb_idx  (req_rm),
        .rb_data (src_b),
        .rc_idx  (peek_idx),
        .rc_data (peek_data)
    );

    mrx_byteswap #(.XLEN(XLEN)) u_swap (
        .op  (op_w),
        .src (src_a),
        .res (swap_res)
    );

    mrx_seqmul #(.XLEN(XLEN)) u_mul (
        .clk    (clk),
        .rst    (rst),
        .start  (mul_start),
        .op_a   (src_a),
        .op_b   (src_b),
        .busy   (mul_busy),
        .last   (mul_last),
        .result (mul_res)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;
        st_d.wbv  = 1'b0;

        accept    = req_valid && !mul_busy;
        is_mul    = (op_w == OP_MUL);
        mul_start = accept && is_mul && (req_rd == req_rm);
        rev_go    = accept && !is_mul;

        if (accept && is_mul && (req_rd != req_rm)) begin
            st_d.err = 1'b1;
        end
        if (mul_start) begin
            st_d.mrd = req_rd;
        end
        if (flag_we) begin
            st_d.flg = flag_in;
        end

        bank_we    = ld_we;
        bank_widx  = ld_idx;
        bank_wdata = ld_data;

        if (mul_last) begin
            bank_we         = 1'b1;
            bank_widx       = st_q.mrd;
            bank_wdata      = mul_res;
            st_d.done       = 1'b1;
            st_d.wbv        = 1'b1;
            st_d.wbidx      = st_q.mrd;
            st_d.wbdata     = mul_res;
            st_d.flg[FLG_N] = mul_res[XLEN-1];
            st_d.flg[FLG_Z] = (mul_res == '0);
        end else if (rev_go) begin
            bank_we     = 1'b1;
            bank_widx   = req_rd;
            bank_wdata  = swap_res;
            st_d.wbv    = 1'b1;
            st_d.wbidx  = req_rd;
            st_d.wbdata = swap_res;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = mul_busy;
    assign done     = st_q.done;
    assign err      = st_q.err;
    assign wb_valid = st_q.wbv;
    assign wb_idx   = st_q.wbidx;
    assign wb_data  = st_q.wbdata;
    assign flags    = st_q.flg;

endmodule

// File: rtl/mulrev_unit_chk.sv
module mulrev_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            flag_we,
    input logic            busy,
    input logic            done,
    input logic            err,
    input logic            wb_valid,
    input logic [XLEN-1:0] wb_data,
    input logic [3:0]      flags
);

    localparam int BW = $clog2(XLEN) + 2;

    logic [BW-1:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_run <= '0;
        end else if (busy) begin
            busy_run <= busy_run + 1'b1;
        end else begin
            busy_run <= '0;
        end
    end

    assert_busy_len_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_run == BW'(XLEN)));

    assert_done_follows_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done && wb_valid));

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_mul_nz_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> ((flags[3] == wb_data[XLEN-1]) && (flags[2] == (wb_data == '0))));

    assert_cv_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !flag_we |=> $stable(flags[1:0]));

    assert_err_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        err |-> (!wb_valid && !busy));

    assert_rev_flags_R9: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && !done && !$past(flag_we)) |-> $stable(flags));

    assert_no_err_busy_R10: assert property (@(posedge clk) disable iff (rst)
        busy |=> !err);

endmodule

bind mulrev_unit mulrev_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .flag_we  (flag_we),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .wb_valid (wb_valid),
    .wb_data  (wb_data),
    .flags    (flags)
);

// File: tb/tb_mulrev_unit.sv
module tb_mulrev_unit;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [2:0]  req_rd = '0, req_rn = '0, req_rm = '0;
    logic        ld_we = 1'b0;
    logic [2:0]  ld_idx = '0;
    logic [31:0] ld_data = '0;
    logic        flag_we = 1'b0;
    logic [3:0]  flag_in = '0;
    logic [2:0]  peek_idx = '0;
    logic [31:0] peek_data, wb_data;
    logic        busy, done, err, wb_valid;
    logic [2:0]  wb_idx;
    logic [3:0]  flags;

    mulrev_unit dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_rd(req_rd), .req_rn(req_rn), .req_rm(req_rm),
        .ld_we(ld_we), .ld_idx(ld_idx), .ld_data(ld_data),
        .flag_we(flag_we), .flag_in(flag_in),
        .peek_idx(peek_idx), .peek_data(peek_data),
        .busy(busy), .done(done), .err(err), .wb_valid(wb_valid),
        .wb_idx(wb_idx), .wb_data(wb_data), .flags(flags)
    );

    typedef struct packed {
        logic [2:0]  idx;
        logic [31:0] data;
        logic        is_mul;
        logic [3:0]  fl;
    } exp_t;

    exp_t        sb_q[$];
    exp_t        mon_e;
    logic [31:0] model [8];
    logic [3:0]  mflags = '0;
    int          total = 0;
    int          bad = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] f_rev(input logic [31:0] x);
        return {x[7:0], x[15:8], x[23:16], x[31:24]};
    endfunction
    function automatic logic [31:0] f_rev16(input logic [31:0] x);
        return {x[23:16], x[31:24], x[7:0], x[15:8]};
    endfunction
    function automatic logic [31:0] f_revsh(input logic [31:0] x);
        return {{16{x[7]}}, x[7:0], x[15:8]};
    endfunction

    // monitor: pops the scoreboard on each write-back
    always @(negedge clk) begin
        if (!rst && wb_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R10 unexpected write-back", wb_data, 32'h0);
            end else begin
                mon_e = sb_q.pop_front();
                check(wb_idx == mon_e.idx, "R11 write-back index", {29'd0, wb_idx}, {29'd0, mon_e.idx});
                check(wb_data == mon_e.data, mon_e.is_mul ? "R2 product low word" : "R6/R7/R8 reverse data",
                      wb_data, mon_e.data);
                check(flags == mon_e.fl, mon_e.is_mul ? "R3 flags after multiply" : "R9 flags after reverse",
                      {28'd0, flags}, {28'd0, mon_e.fl});
                check(done == mon_e.is_mul, "R5 done only for multiply", {31'd0, done}, {31'd0, mon_e.is_mul});
            end
        end
    end

    task automatic load_reg(input logic [2:0] idx, input logic [31:0] val);
        @(negedge clk);
        ld_we = 1'b1; ld_idx = idx; ld_data = val;
        @(negedge clk);
        ld_we = 1'b0;
        model[idx] = val;
    endtask

    task automatic load_flags(input logic [3:0] val);
        @(negedge clk);
        flag_we = 1'b1; flag_in = val;
        @(negedge clk);
        flag_we = 1'b0;
        mflags = val;
    endtask

    task automatic peek(input logic [2:0] idx, input logic [31:0] exp, input string tag);
        peek_idx = idx;
        #1;
        check(peek_data == exp, tag, peek_data, exp);
    endtask

    // presents a request for one cycle; pushes the expected result when it should be accepted
    task automatic issue(input logic [1:0] op, input logic [2:0] rd, input logic [2:0] rn,
                         input logic [2:0] rm, input bit accepted);
        exp_t        e;
        logic [63:0] p;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_rd = rd; req_rn = rn; req_rm = rm;
        if (accepted && !(op == 2'd0 && rd != rm)) begin
            e.idx    = rd;
            e.is_mul = (op == 2'd0);
            case (op)
                2'd0: begin
                    p      = {32'd0, model[rn]} * {32'd0, model[rm]};
                    e.data = p[31:0];
                    e.fl   = {e.data[31], e.data == 32'd0, mflags[1:0]};
                end
                2'd1: begin e.data = f_rev(model[rn]);   e.fl = mflags; end
                2'd2: begin e.data = f_rev16(model[rn]); e.fl = mflags; end
                default: begin e.data = f_revsh(model[rn]); e.fl = mflags; end
            endcase
            sb_q.push_back(e);
            model[rd] = e.data;
            mflags    = e.fl;
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_mul(output int n);
        n = busy ? 1 : 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (done) break;
            if (busy) n++;
        end
    endtask

    initial begin
        int n;
        for (int i = 0; i < 8; i++) model[i] = 32'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check(busy == 0 && done == 0 && err == 0 && wb_valid == 0, "R1 control outputs after reset",
              {28'd0, busy, done, err, wb_valid}, 32'd0);
        check(flags == 4'd0, "R1 flags after reset", {28'd0, flags}, 32'd0);
        for (int i = 0; i < 8; i++) peek(3'(i), 32'd0, "R1 register after reset");

        // R11: load port
        load_reg(3'd1, 32'h11223344);
        load_reg(3'd2, 32'h80FF7F01);
        load_reg(3'd3, 32'd5);
        load_reg(3'd4, 32'hFFFFFFFD);
        load_reg(3'd6, 32'h000012F0);
        peek(3'd4, 32'hFFFFFFFD, "R11 load then peek");
        load_flags(4'b0011);
        check(flags == 4'b0011, "R11 flag load", {28'd0, flags}, 32'h3);

        // R6, R7, R8, R9: reverse operations
        issue(2'd1, 3'd0, 3'd1, 3'd0, 1'b1);
        peek(3'd0, 32'h44332211, "R9 reverse result present next cycle (R6)");
        issue(2'd2, 3'd7, 3'd1, 3'd0, 1'b1);
        peek(3'd7, 32'h22114433, "R7 halfword reverse");
        issue(2'd3, 3'd5, 3'd6, 3'd0, 1'b1);
        peek(3'd5, 32'hFFFFF012, "R8 negative sign extension");
        issue(2'd3, 3'd0, 3'd2, 3'd0, 1'b1);
        peek(3'd0, 32'h0000017F, "R8 positive sign extension");
        issue(2'd2, 3'd0, 3'd2, 3'd0, 1'b1);
        peek(3'd0, 32'hFF80017F, "R7 halfword reverse second pattern");
        check(flags == 4'b0011, "R9 flags untouched by reverses", {28'd0, flags}, 32'h3);

        // R2, R3, R5: mixed-sign multiply
        issue(2'd0, 3'd4, 3'd3, 3'd4, 1'b1);
        wait_mul(n);
        check(n == 32, "R5 busy cycle count", n, 32);
        peek(3'd4, 32'hFFFFFFF1, "R2 signed-looking product");
        check(flags == 4'b1011, "R3 N set, C V kept", {28'd0, flags}, 32'hB);

        // zero product
        load_reg(3'd5, 32'd0);
        issue(2'd0, 3'd5, 3'd1, 3'd5, 1'b1);
        wait_mul(n);
        check(n == 32, "R5 busy cycle count zero product", n, 32);
        check(flags == 4'b0111, "R3 Z set on zero product", {28'd0, flags}, 32'h7);

        // overflowing product, C V cleared beforehand
        load_flags(4'b0000);
        issue(2'd0, 3'd7, 3'd1, 3'd7, 1'b1);
        wait_mul(n);
        peek(3'd7, model[7], "R2 overflowing product low word");

        // R4: rejected multiply
        load_flags(4'b0010);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd0; req_rd = 3'd0; req_rn = 3'd1; req_rm = 3'd2;
        @(negedge clk);
        req_valid = 1'b0;
        check(err == 1'b1, "R4 err pulse", {31'd0, err}, 32'd1);
        check(busy == 1'b0 && wb_valid == 1'b0, "R4 nothing started",
              {30'd0, busy, wb_valid}, 32'd0);
        @(negedge clk);
        check(err == 1'b0, "R4 err lasts one cycle", {31'd0, err}, 32'd0);
        peek(3'd0, model[0], "R4 destination unchanged");
        check(flags == 4'b0010, "R4 flags unchanged", {28'd0, flags}, 32'h2);

        // R10: requests while busy are ignored
        issue(2'd0, 3'd3, 3'd3, 3'd3, 1'b1);
        issue(2'd1, 3'd2, 3'd1, 3'd0, 1'b0);
        check(err == 1'b0, "R10 no err while busy", {31'd0, err}, 32'd0);
        issue(2'd0, 3'd0, 3'd1, 3'd2, 1'b0);
        check(err == 1'b0, "R10 rejected shape ignored while busy", {31'd0, err}, 32'd0);
        for (int i = 0; i < 100; i++) begin
            if (done) break;
            @(negedge clk);
        end
        peek(3'd2, model[2], "R10 ignored reverse left register");
        peek(3'd3, 32'd25, "R2 square of five");

        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R9 all expected write-backs seen", sb_q.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule